// File: doc/BRIEF.md
# Configuration Bitstream Loader

This block takes a configuration image from a host and passes it, one 32-bit word at a time, into the configuration port of a downstream device. The host first writes the image length in bytes while the loader is idle. It then enables the loader. Words reach the loader through a data window in the register space. Either the processor writes them directly, or an external DMA engine writes them when the loader raises its request line. The loader keeps a byte count of the words the device has taken and stops streaming once that count equals the programmed length. It then waits for the device to report that configuration is done.

The run ends in one of four ways: completion, a device error, an overflowing write, or a device that never reports done within a bounded number of cycles. Each of these sets a sticky interrupt. Software reads the status word to find the cause. It then writes zero to the control register, which clears the interrupt and flushes any words that were not sent. Writing the enable and reset bits together drives the device's configuration reset line for as long as both bits stay set.

The FIFO depth must be a power of two.

Top module: `cfgload_ctrl`

## Requirements
- R1: After reset the control, status, used-words and current-count registers read 0. `irq`, `dma_req`, `cfg_valid` and `cfg_rst` are low. The size register (offset 0x48) reads 4 × FIFO_DEPTH.
- R2: The byte-total register (offset 0x50) takes a write only while control bit 0 (enable) is clear. A write while enabled leaves its value unchanged.
- R3: A write to offset 0x3000 while enabled and the FIFO is not full is presented on `cfg_data` in write order, and one word leaves on each cycle with `cfg_valid` and `cfg_ready` both high. A write to that offset while disabled is discarded, so the used-words register stays 0.
- R4: Each accepted word adds 4 to the current-count register (offset 0x54). `cfg_valid` stays low once that count equals the byte total, even if words remain in the FIFO.
- R5: The used-words register (offset 0x4C) reports the FIFO occupancy in words and reads 0 once the FIFO has drained.
- R6: Once the count equals the total and `cfg_done` is high, `irq` and status bit 16 are set. Status bit 18 follows `cfg_done` one cycle late.
- R7: If the total has been reached and `cfg_done` stays low for DONE_TIMEOUT cycles, status bit 3 and `irq` are set. Neither is set earlier.
- R8: `cfg_err` high while enabled and not in reset sets status bit 1 and `irq`, and `cfg_valid` stays low from then on.
- R9: A data write while the FIFO is full is dropped, and it sets status bit 2 and `irq`. Status bits 15:1 form the error field, and status bit 0 is high while a run is active with no interrupt pending.
- R10: `irq` stays high until a control write with bit 0 clear. That write clears `irq` and empties the FIFO.
- R11: `dma_req` is high only while control bits 0 and 2 are set, bit 1 is clear, no interrupt is pending, and at least FIFO_DEPTH/2 words are free.
- R12: `cfg_rst` is high exactly while control bits 0 and 1 are both set. Writing 3 and then 0 to control produces a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 14 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cfg_data | output | 32 | Word offered to the device |
| cfg_valid | output | 1 | `cfg_data` is valid |
| cfg_ready | input | 1 | Device accepts the offered word |
| cfg_done | input | 1 | Device reports configuration done |
| cfg_err | input | 1 | Device reports a configuration error |
| cfg_rst | output | 1 | Device configuration reset |
| dma_req | output | 1 | Request for a burst of FIFO_DEPTH/2 words |
| irq | output | 1 | Sticky end-of-run interrupt |

## Verification
The bench aims at the exact end of the byte count. It writes one word more than the total. A loader that compared the count loosely would stream the extra word, and the scoreboard would see an unexpected item. The half-free threshold of the request line is tested one word on each side. A design that used the wrong comparison would keep requesting when the FIFO is half full plus one. The timeout is checked both before and after it should fire, so a counter that is off by a large margin in either direction is caught. The bench also checks that the interrupt survives unrelated register writes, and that a disable both clears the interrupt and empties the FIFO.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  localparam int unsigned ADDR_W = 14;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 14'h0040;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 14'h0044;
  localparam logic [ADDR_W-1:0] OFS_FSIZE = 14'h0048;
  localparam logic [ADDR_W-1:0] OFS_USED  = 14'h004C;
  localparam logic [ADDR_W-1:0] OFS_TOTAL = 14'h0050;
  localparam logic [ADDR_W-1:0] OFS_CUR   = 14'h0054;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 14'h3000;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_RST = 1;
  localparam int unsigned CTL_DMA = 2;

  typedef struct packed {
    logic tmo;
    logic ovf;
    logic dev;
  } err_t;

  // bytes consumed after one more word
  function automatic logic [WORD_W-1:0] advance_bytes(input logic [WORD_W-1:0] cur);
    return cur + 32'd4;
  endfunction

  // true when a half-FIFO burst fits
  function automatic logic burst_room(input logic [31:0] used, input logic [31:0] depth);
    return (depth - used) >= (depth >> 1);
  endfunction

  // status word: bit0 active, bits 3:1 errors, bit16 irq, bit18 done
  function automatic logic [WORD_W-1:0] pack_status(input logic active, input err_t err,
                                                     input logic irq, input logic done);
    return {13'd0, done, 1'b0, irq, 12'd0, err.tmo, err.ovf, err.dev, active};
  endfunction

endpackage

// File: rtl/cfgload_fifo.sv
module cfgload_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/cfgload_regs.sv
module cfgload_regs
  import cfgload_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] status_word,
  input  logic [WORD_W-1:0] used_word,
  input  logic [WORD_W-1:0] cur_bytes,
  output logic              ctrl_en,
  output logic              ctrl_rst,
  output logic              ctrl_dma,
  output logic [WORD_W-1:0] total_bytes,
  output logic              enable_rise,
  output logic              disable_wr,
  output logic              data_wr
);

  localparam logic [WORD_W-1:0] SIZE_BYTES = WORD_W'(FIFO_DEPTH * 4);

  logic ctrl_sel, total_sel;
  logic [2:0] ctrl_q;

  assign ctrl_sel    = bus_wr && (bus_addr == OFS_CTRL);
  assign total_sel   = bus_wr && (bus_addr == OFS_TOTAL);
  assign enable_rise = ctrl_sel && bus_wdata[CTL_EN] && !ctrl_q[CTL_EN];
  assign disable_wr  = ctrl_sel && !bus_wdata[CTL_EN];
  assign data_wr     = bus_wr && (bus_addr == OFS_DATA) && ctrl_q[CTL_EN];

  assign ctrl_en  = ctrl_q[CTL_EN];
  assign ctrl_rst = ctrl_q[CTL_RST];
  assign ctrl_dma = ctrl_q[CTL_DMA];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      total_bytes <= '0;
    end else begin
      if (ctrl_sel) ctrl_q <= bus_wdata[2:0];
      if (total_sel && !ctrl_q[CTL_EN]) total_bytes <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:  bus_rdata = {29'd0, ctrl_q};
      OFS_STAT:  bus_rdata = status_word;
      OFS_FSIZE: bus_rdata = SIZE_BYTES;
      OFS_USED:  bus_rdata = used_word;
      OFS_TOTAL: bus_rdata = total_bytes;
      OFS_CUR:   bus_rdata = cur_bytes;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cfgload_seq.sv
module cfgload_seq
  import cfgload_pkg::*;
#(
  parameter int unsigned DONE_TIMEOUT = 64,
  localparam int unsigned TMO_W = $clog2(DONE_TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic              ctrl_rst,
  input  logic              enable_rise,
  input  logic              disable_wr,
  input  logic [WORD_W-1:0] total_bytes,
  input  logic              fifo_empty,
  input  logic              overflow_wr,
  input  logic              cfg_ready,
  input  logic              cfg_done,
  input  logic              cfg_err,
  output logic              armed,
  output logic              cfg_valid,
  output logic              accept,
  output logic [WORD_W-1:0] cur_bytes,
  output err_t              err,
  output logic              irq,
  output logic              done_q
);

  logic err_q, reached, waiting;
  logic complete_evt, tmo_evt, dev_evt, ovf_evt;
  logic [TMO_W-1:0] tmo_cnt;

  assign armed        = ctrl_en && !ctrl_rst;
  assign reached      = (cur_bytes == total_bytes);
  assign cfg_valid    = armed && !irq && !fifo_empty && !reached;
  assign accept       = cfg_valid && cfg_ready;
  assign waiting      = armed && !irq && reached && !done_q;
  assign complete_evt = armed && !irq && reached && done_q;
  assign tmo_evt      = waiting && (tmo_cnt == TMO_W'(DONE_TIMEOUT - 1));
  assign dev_evt      = armed && err_q;
  assign ovf_evt      = overflow_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= cfg_done;
      err_q  <= cfg_err;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bytes <= '0;
      err       <= '0;
      tmo_cnt   <= '0;
      irq       <= 1'b0;
    end else begin
      if (enable_rise) begin
        cur_bytes <= '0;
        err       <= '0;
        tmo_cnt   <= '0;
      end else begin
        if (accept)  cur_bytes <= advance_bytes(cur_bytes);
        if (dev_evt) err.dev <= 1'b1;
        if (ovf_evt) err.ovf <= 1'b1;
        if (tmo_evt) err.tmo <= 1'b1;
        if (waiting) tmo_cnt <= tmo_cnt + 1'b1;
      end
      if (disable_wr || enable_rise) begin
        irq     <= 1'b0;
        tmo_cnt <= '0;
      end else if (dev_evt || ovf_evt || tmo_evt || complete_evt) begin
        irq <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH   = 16,
  parameter int unsigned DONE_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [13:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [31:0] cfg_data,
  output logic        cfg_valid,
  input  logic        cfg_ready,
  input  logic        cfg_done,
  input  logic        cfg_err,
  output logic        cfg_rst,
  output logic        dma_req,
  output logic        irq
);

  localparam int unsigned USED_W = $clog2(FIFO_DEPTH + 1);

  logic              ctrl_en, ctrl_rst, ctrl_dma;
  logic              enable_rise, disable_wr, data_wr;
  logic              fifo_push, fifo_full, fifo_empty, accept, armed, done_q;
  logic [USED_W-1:0] used_cnt;
  logic [31:0]       total_bytes, cur_bytes, status_word;
  err_t              err;

  cfgload_regs #(.FIFO_DEPTH(FIFO_DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_word(status_word),
    .used_word(32'(used_cnt)), .cur_bytes(cur_bytes), .ctrl_en(ctrl_en),
    .ctrl_rst(ctrl_rst), .ctrl_dma(ctrl_dma), .total_bytes(total_bytes),
    .enable_rise(enable_rise), .disable_wr(disable_wr), .data_wr(data_wr)
  );

  assign fifo_push = data_wr && !fifo_full;

  cfgload_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(disable_wr || enable_rise),
    .push(fifo_push), .din(bus_wdata), .pop(accept), .dout(cfg_data),
    .count(used_cnt), .full(fifo_full), .empty(fifo_empty)
  );

  cfgload_seq #(.DONE_TIMEOUT(DONE_TIMEOUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .ctrl_rst(ctrl_rst),
    .enable_rise(enable_rise), .disable_wr(disable_wr), .total_bytes(total_bytes),
    .fifo_empty(fifo_empty), .overflow_wr(data_wr && fifo_full),
    .cfg_ready(cfg_ready), .cfg_done(cfg_done), .cfg_err(cfg_err),
    .armed(armed), .cfg_valid(cfg_valid), .accept(accept), .cur_bytes(cur_bytes),
    .err(err), .irq(irq), .done_q(done_q)
  );

  assign status_word = pack_status(armed && !irq, err, irq, done_q);
  assign cfg_rst     = ctrl_en && ctrl_rst;
  assign dma_req     = armed && ctrl_dma && !irq &&
                       burst_room(32'(used_cnt), 32'(FIFO_DEPTH));

endmodule

// File: rtl/cfgload_checker.sv
module cfgload_checker #(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned USED_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_en,
  input logic              ctrl_dma,
  input logic              armed,
  input logic              disable_wr,
  input logic              accept,
  input logic              cfg_valid,
  input logic              dma_req,
  input logic              irq,
  input logic [31:0]       cur_bytes,
  input logic [31:0]       total_bytes,
  input logic [USED_W-1:0] used_cnt
);

  // R2
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> $stable(total_bytes));

  // R3
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (armed && used_cnt != '0));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cur_bytes == $past(cur_bytes) + 32'd4));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cur_bytes <= total_bytes));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt <= USED_W'(FIFO_DEPTH));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !disable_wr) |=> irq);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disable_wr |=> (used_cnt == '0));

  // R11
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (armed && ctrl_dma && !irq));

endmodule

bind cfgload_ctrl cfgload_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .ctrl_dma(ctrl_dma), .armed(armed),
  .disable_wr(disable_wr), .accept(accept), .cfg_valid(cfg_valid), .dma_req(dma_req),
  .irq(irq), .cur_bytes(cur_bytes), .total_bytes(total_bytes), .used_cnt(used_cnt)
);

// File: tb/cfgload_ctrl_bench.sv
`timescale 1ns/1ps
module cfgload_ctrl_bench;

  localparam int DEPTH = 16;
  localparam int TMO   = 64;
  localparam logic [13:0] A_CTRL = 14'h0040, A_STAT = 14'h0044, A_SIZE = 14'h0048,
                          A_USED = 14'h004C, A_TOT = 14'h0050, A_CUR = 14'h0054,
                          A_DATA = 14'h3000;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cfg_data;
  logic        cfg_valid, cfg_ready = 0, cfg_done = 0, cfg_err = 0, cfg_rst, dma_req, irq;

  int n_checks = 0, n_fail = 0;
  int ready_mode = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  cfgload_ctrl #(.FIFO_DEPTH(DEPTH), .DONE_TIMEOUT(TMO)) u_cfgload_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_data(cfg_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_done(cfg_done),
    .cfg_err(cfg_err), .cfg_rst(cfg_rst), .dma_req(dma_req), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d, input bit expect_out = 0);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    if (a == A_CTRL) exp_q.delete();
    if (expect_out) exp_q.push_back(d);
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic drain();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(A_USED, v);
      if (v == 0) break;
    end
  endtask

  // ready pattern driver
  initial forever begin
    @(posedge clk); #1;
    cfg_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 2) ? ~cfg_ready : 1'b0;
  end

  // scoreboard monitor (R3): an accept at the coming edge must match the queue head
  always @(negedge clk) begin
    if (rst_n && cfg_valid && cfg_ready) begin
      if (exp_q.size() == 0) check("R3 unexpected word", cfg_data, 32'hxxxxxxxx);
      else check("R3 stream order", cfg_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    rd(A_USED, v); check("R1 used", v, 0);
    rd(A_CUR, v);  check("R1 cur", v, 0);
    rd(A_SIZE, v); check("R1 size", v, DEPTH * 4);
    check("R1 outputs", {irq, dma_req, cfg_valid, cfg_rst}, 0);

    // R3 write while disabled is discarded
    wr(A_DATA, 32'hDEAD0000);
    rd(A_USED, v); check("R3 disabled write", v, 0);

    // run 1: timeout path
    wr(A_TOT, 32'h20);
    rd(A_TOT, v); check("R2 total write", v, 32'h20);
    wr(A_CTRL, 1);
    wr(A_TOT, 32'h99);
    rd(A_TOT, v); check("R2 total ignored", v, 32'h20);
    rd(A_STAT, v); check("R9 active bit", v, 32'h1);
    for (int i = 0; i < 8; i++) wr(A_DATA, 32'hA5000000 + i, 1);
    rd(A_USED, v); check("R5 used count", v, 8);
    ready_mode = 2;
    drain();
    rd(A_USED, v); check("R5 drained", v, 0);
    rd(A_CUR, v);  check("R4 byte count", v, 32'h20);
    check("R3 all words out", exp_q.size(), 0);
    check("R7 not early", irq, 0);
    repeat (TMO + 4) @(posedge clk);
    #1 check("R7 timeout irq", irq, 1);
    rd(A_STAT, v); check("R7 timeout status", v, 32'h0001_0008);
    wr(A_TOT, 32'h4);
    repeat (10) @(posedge clk);
    #1 check("R10 irq sticky", irq, 1);
    wr(A_CTRL, 0);
    #1 check("R10 irq cleared", irq, 0);

    // run 2: completion, extra word held back
    ready_mode = 1; cfg_done = 1;
    wr(A_TOT, 32'h10);
    wr(A_CTRL, 1);
    for (int i = 0; i < 5; i++) wr(A_DATA, 32'h5A000010 + i, i < 4);
    repeat (4) @(posedge clk);
    #1 check("R6 done irq", irq, 1);
    check("R4 stops at total", cfg_valid, 0);
    rd(A_USED, v); check("R4 leftover word", v, 1);
    rd(A_CUR, v);  check("R4 count at total", v, 32'h10);
    rd(A_STAT, v); check("R6 done status", v, 32'h0005_0000);
    wr(A_CTRL, 0);
    rd(A_USED, v); check("R10 flush", v, 0);
    cfg_done = 0;

    // device error
    ready_mode = 0;
    wr(A_TOT, 32'h40);
    wr(A_CTRL, 1);
    @(posedge clk); #1 cfg_err = 1;
    @(posedge clk); #1 cfg_err = 0;
    repeat (3) @(posedge clk);
    #1 check("R8 error irq", irq, 1);
    rd(A_STAT, v); check("R8 error status", v, 32'h0001_0002);
    ready_mode = 1;
    wr(A_DATA, 32'h1234);
    #1 check("R8 halted", cfg_valid, 0);
    ready_mode = 0;
    wr(A_CTRL, 0);

    // overflow
    wr(A_TOT, 32'h100);
    wr(A_CTRL, 1);
    for (int i = 0; i < DEPTH; i++) wr(A_DATA, i);
    #1 check("R9 no irq at full", irq, 0);
    wr(A_DATA, 32'hFFFF);
    rd(A_USED, v); check("R9 word dropped", v, DEPTH);
    rd(A_STAT, v); check("R9 overflow status", v, 32'h0001_0004);
    wr(A_CTRL, 0);

    // DMA request threshold
    wr(A_CTRL, 1);
    #1 check("R11 no dma bit", dma_req, 0);
    wr(A_CTRL, 5);
    #1 check("R11 request empty", dma_req, 1);
    for (int i = 0; i < DEPTH / 2; i++) wr(A_DATA, i);
    #1 check("R11 half free", dma_req, 1);
    wr(A_DATA, 32'h99);
    #1 check("R11 below half", dma_req, 0);
    wr(A_CTRL, 0);
    #1 check("R11 disabled", dma_req, 0);

    // reset pulse
    wr(A_CTRL, 3);
    #1 check("R12 reset high", cfg_rst, 1);
    check("R11 no dma in reset", dma_req, 0);
    wr(A_CTRL, 0);
    #1 check("R12 reset low", cfg_rst, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule